// File: doc/BRIEF.md
# Eight-pin bidirectional I/O port with upper-nibble change detection

This block is one general-purpose I/O port of eight pins. A small register interface reaches two registers: the port data register and the direction register. Writing the data register loads an output latch that drives the pad output. Reading it returns the pin levels as they arrive through a two-flop synchronizer, not the latch contents. Each direction bit decides whether its pin is an input or is driven from the latch.

The four upper pins also feed a change detector. Every read of the data register stores a reference copy of those four synchronized pins. When any upper pin that is set as an input later differs from its reference, a sticky flag rises. It stays high until software clears it, usually after it has read the port again to refresh the reference. The lower four pins and any upper pin set as an output never raise the flag.

Top module: `gpio_chg_port`

## Requirements
- R1: While reset is asserted and just after it is released, every direction bit is 1 (pad_oe = 0x00), chg_flag is 0 and bus_rdata is 0x00.
- R2: Writing the direction register (bus_addr = 1) sets pad_oe to the bitwise inverse of the written byte from the next clock edge, so a 1 makes a pin an input and a 0 makes it an output.
- R3: A read of the data register (bus_addr = 0) puts on bus_rdata, one edge after the read strobe, the pad_in levels that have passed through two synchronizer flops.
- R4: Writing the data register (bus_addr = 0) loads the output latch, and pad_out shows it from the next edge. A later read of address 0 returns the pin levels and not the latch.
- R5: A latch value written while its pins are inputs is kept, and it appears on those pins once their direction bits are cleared.
- R6: When an upper pin (7:4) set as an input differs from the reference stored at the last data read, chg_flag is set on the third clock edge after the pad changes.
- R7: A change on pins 3:0 never sets chg_flag.
- R8: An upper pin whose direction bit is 0 is left out of the comparison. Setting it back to an input while it differs from the reference sets the flag.
- R9: chg_flag stays set until chg_clr is pulsed. If a mismatch is still present in the cycle of the clear, the flag stays set.
- R10: A read of the direction register (bus_addr = 1) returns its current value on bus_rdata one edge after the strobe.
- R11: A data read refreshes the reference, so a clear that follows it leaves chg_flag low while the pins hold still.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously |
| bus_addr | input | 2 | Register select: 0 data, 1 direction |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pad_in | input | 8 | Pin levels from the pads |
| pad_out | output | 8 | Output latch toward the pads |
| pad_oe | output | 8 | Per-pin output enable, 1 = driven |
| chg_clr | input | 1 | Clears the change flag |
| chg_flag | output | 1 | Sticky change flag for pins 7:4 |

## Verification
Register writes show on pad_out and pad_oe one edge after the strobe. Read data is due one edge after the read strobe. A pad change reaches the second synchronizer stage after two edges and the flag after three. The bench drives every input on the falling edge and samples on a later falling edge, counted to those latencies. For R6 it also checks that the flag is still low one edge before it is due. The clear behaviour is checked one falling edge after the clear pulse.

// File: rtl/gpio_chg_pkg.sv
package gpio_chg_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] REG_DATA = 2'd0;
  localparam logic [ADDR_W-1:0] REG_DIR  = 2'd1;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[0] <= '0;
        else        stg[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[g] <= '0;
        else        stg[g] <= stg[g-1];
      end
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_chg_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int CHG_LO = 4,
  localparam int HI_W  = WIDTH - CHG_LO
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [WIDTH-1:0]  pins,
  output logic [WIDTH-1:0]  latch_q,
  output logic [WIDTH-1:0]  dir_q,
  output logic [WIDTH-1:0]  rdata_q,
  output logic [HI_W-1:0]   ref_q
);
  logic             lat_en, dir_en, rd_en, ref_en;
  logic [WIDTH-1:0] rdata_d;

  always_comb begin
    lat_en  = wr && (addr == REG_DATA);
    dir_en  = wr && (addr == REG_DIR);
    rd_en   = rd;
    ref_en  = rd && (addr == REG_DATA);
    rdata_d = '0;
    if (addr == REG_DATA)     rdata_d = pins;
    else if (addr == REG_DIR) rdata_d = dir_q;
  end

  // output latch carries no reset: its value is undefined until written
  always_ff @(posedge clk) begin
    if (lat_en) latch_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q   <= '1;
      rdata_q <= '0;
      ref_q   <= '0;
    end else begin
      if (dir_en) dir_q   <= wdata;
      if (rd_en)  rdata_q <= rdata_d;
      if (ref_en) ref_q   <= pins[WIDTH-1:CHG_LO];
    end
  end
endmodule

// File: rtl/gpio_chg_det.sv
module gpio_chg_det #(
  parameter int HI_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [HI_W-1:0] pins_hi,
  input  logic [HI_W-1:0] ref_hi,
  input  logic [HI_W-1:0] in_mode,
  input  logic            clr,
  output logic            flag_q
);
  logic            mismatch;
  logic            flag_d;
  logic [HI_W-1:0] diff;

  always_comb begin
    diff     = (pins_hi ^ ref_hi) & in_mode;
    mismatch = |diff;
    flag_d   = mismatch | (flag_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end
endmodule

// File: rtl/gpio_chg_port.sv
module gpio_chg_port
  import gpio_chg_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int CHG_LO      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int HI_W       = WIDTH - CHG_LO
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe,
  input  logic              chg_clr,
  output logic              chg_flag
);
  logic [WIDTH-1:0] pins_s;
  logic [WIDTH-1:0] dir;
  logic [HI_W-1:0]  ref_hi;

  gpio_sync #(.W(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pad_in), .q(pins_s)
  );

  gpio_regs #(.WIDTH(WIDTH), .CHG_LO(CHG_LO)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .pins(pins_s), .latch_q(pad_out), .dir_q(dir),
    .rdata_q(bus_rdata), .ref_q(ref_hi)
  );

  gpio_chg_det #(.HI_W(HI_W)) u_det (
    .clk(clk), .rst_n(rst_n), .pins_hi(pins_s[WIDTH-1:CHG_LO]),
    .ref_hi(ref_hi), .in_mode(dir[WIDTH-1:CHG_LO]), .clr(chg_clr),
    .flag_q(chg_flag)
  );

  assign pad_oe = ~dir;
endmodule

// File: rtl/gpio_chg_port_chk.sv
module gpio_chg_port_chk
  import gpio_chg_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int CHG_LO = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [WIDTH-1:0]  bus_wdata,
  input logic [WIDTH-1:0]  bus_rdata,
  input logic [WIDTH-1:0]  pad_out,
  input logic [WIDTH-1:0]  pad_oe,
  input logic              chg_clr,
  input logic              chg_flag
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_oe == '0 && !chg_flag && bus_rdata == '0));

  // R2
  dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == REG_DIR) |=> (pad_oe == ~$past(bus_wdata)));

  // R4
  latch_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == REG_DATA) |=> (pad_out == $past(bus_wdata)));

  // R8
  out_pins_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(chg_flag) |-> ($past(pad_oe[WIDTH-1:CHG_LO]) != '1));

  // R9
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_flag && !chg_clr) |=> chg_flag);

  // R10
  dir_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == REG_DIR) |=> (bus_rdata == ~$past(pad_oe)));
endmodule

bind gpio_chg_port gpio_chg_port_chk #(.WIDTH(WIDTH), .CHG_LO(CHG_LO)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pad_out(pad_out), .pad_oe(pad_oe), .chg_clr(chg_clr), .chg_flag(chg_flag)
);

// File: tb/sim_gpio_chg_port.sv
module sim_gpio_chg_port;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [1:0] bus_addr;
  logic       bus_wr, bus_rd, chg_clr, chg_flag;
  logic [7:0] bus_wdata, bus_rdata, pad_in, pad_out, pad_oe;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  gpio_chg_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .chg_clr(chg_clr), .chg_flag(chg_flag)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    chg_clr = 1'b1;
    @(negedge clk);
    chg_clr = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 pad_oe", pad_oe, 8'h00);
    chk("R1 flag", {7'b0, chg_flag}, 8'h00);
    chk("R1 rdata", bus_rdata, 8'h00);
  endtask

  task automatic t_dir_latch();
    logic [7:0] r;
    bus_write(2'd0, 8'hA5);
    chk("R4 pad_out", pad_out, 8'hA5);
    bus_write(2'd1, 8'h0F);
    chk("R2 pad_oe", pad_oe, 8'hF0);
    bus_read(2'd1, r);
    chk("R10 dir read", r, 8'h0F);
  endtask

  task automatic t_readback();
    logic [7:0] r;
    bus_write(2'd1, 8'hFF);
    pad_in = 8'h3C;
    wait_n(3);
    bus_read(2'd0, r);
    chk("R3 pin read", r, 8'h3C);
    chk("R4 latch kept", pad_out, 8'hA5);
  endtask

  task automatic t_latch_hold();
    bus_write(2'd0, 8'h5A);
    chk("R5 oe while input", pad_oe, 8'h00);
    bus_write(2'd1, 8'h00);
    chk("R5 pad_out", pad_out, 8'h5A);
    chk("R5 pad_oe", pad_oe, 8'hFF);
    bus_write(2'd1, 8'hFF);
  endtask

  task automatic t_change();
    logic [7:0] r;
    pad_in = 8'h00;
    wait_n(3);
    bus_read(2'd0, r);
    pulse_clr();
    chk("R11 cleared", {7'b0, chg_flag}, 8'h00);
    pad_in = 8'h20;
    wait_n(2);
    chk("R6 not yet", {7'b0, chg_flag}, 8'h00);
    wait_n(1);
    chk("R6 set", {7'b0, chg_flag}, 8'h01);
    pad_in = 8'h00;
    wait_n(4);
    chk("R9 sticky", {7'b0, chg_flag}, 8'h01);
    pulse_clr();
    chk("R9 cleared", {7'b0, chg_flag}, 8'h00);
    pad_in = 8'h04;
    wait_n(4);
    chk("R7 low pins", {7'b0, chg_flag}, 8'h00);
  endtask

  task automatic t_out_excluded();
    logic [7:0] r;
    bus_write(2'd1, 8'h0F);
    pad_in = 8'hF4;
    wait_n(4);
    chk("R8 outputs ignored", {7'b0, chg_flag}, 8'h00);
    bus_write(2'd1, 8'hFF);
    wait_n(1);
    chk("R8 re-enabled", {7'b0, chg_flag}, 8'h01);
    bus_read(2'd0, r);
    pulse_clr();
    wait_n(4);
    chk("R11 ref refreshed", {7'b0, chg_flag}, 8'h00);
  endtask

  task automatic t_clr_collide();
    pad_in = 8'h74;
    wait_n(4);
    chk("R6 pin7 fall", {7'b0, chg_flag}, 8'h01);
    pulse_clr();
    chk("R9 clear vs mismatch", {7'b0, chg_flag}, 8'h01);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus_addr = 2'd0; bus_wr = 1'b0; bus_rd = 1'b0;
    bus_wdata = 8'h00; pad_in = 8'h00; chg_clr = 1'b0;
    wait_n(3);
    t_reset();
    rst_n = 1'b1;
    wait_n(1);
    t_reset();
    t_dir_latch();
    t_readback();
    t_latch_hold();
    t_change();
    t_out_excluded();
    t_clr_collide();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule